// File: doc/BRIEF.md
# Flag-Driven Audio Sample Concealment

This block repairs a stream of 16-bit audio samples that arrive tagged with a per-sample error flag produced by the second error-correction stage (that flag already merges the first-stage flags with the second-stage correction result). Samples arrive one at a time on a valid/ready input, each with a channel number. The block returns a sample stream of the same shape in which every flagged sample has been replaced by an estimate.

A flagged sample that sits alone between two clean samples of its own channel is replaced by the mean of those two neighbours. A flagged sample that touches another flagged sample, either before or after it in its channel, is replaced by the last clean value seen on that channel. To know the next neighbour, the block holds each channel's newest sample back until the following sample of the same channel arrives. Each channel keeps its own history, so interleaved left and right streams never affect one another.

Top module: `conceal_top`

## Requirements
- R1: A sample with flag 0 (flag 1 marks an error) is emitted with its value unchanged.
- R2: A flagged sample whose previous and next samples on the same channel both have flag 0 is emitted as floor((prev + next) / 2), computed on signed two's-complement values without overflow.
- R3: A flagged sample whose previous or next sample on the same channel is also flagged is emitted as the most recent flag-0 value of that channel.
- R4: A flagged sample on a channel that has seen no flag-0 sample since reset is emitted as 0.
- R5: Channels are handled independently; samples of one channel never change the result for another (channel number 0 is left, 1 is right).
- R6: The result for a sample is presented on out_valid in the cycle after the next sample of the same channel is accepted, with out_chan equal to that channel; accepting the first sample of a channel after reset produces no output.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_chan hold, in_ready is 0 and no input is taken.
- R8: Synchronous active-high reset clears out_valid, raises in_ready and discards all channel history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take an input sample |
| in_chan | input | 1 | Channel of the input sample (0 left, 1 right) |
| in_flag | input | 1 | Error flag of the input sample, 1 = bad |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output sample |
| out_chan | output | 1 | Channel of the output sample |
| out_data | output | 16 | Signed concealed sample |

## Verification
Every result leaves the block exactly one clock edge after the input that completes its neighbourhood is accepted: the same edge that takes the next same-channel sample loads the output register, so the bench drives a sample before a rising edge and reads out_valid and out_data one time unit after that same edge. A stalled output must remain unchanged across every later edge until out_ready returns, which the bench checks after a whole stalled cycle. The first sample of each channel and the first sample after reset are checked for the absence of output at that same point.

// File: rtl/conceal_pkg.sv
package conceal_pkg;

    localparam int SMP_W = 16;
    localparam int CH_N  = 2;

    typedef logic signed [SMP_W-1:0] smp_t;

    typedef struct packed {
        logic bad;
        smp_t val;
    } tagged_smp_t;

    typedef enum logic [1:0] {
        ACT_PASS,
        ACT_BLEND,
        ACT_HOLD,
        ACT_SILENT
    } act_e;

    // Floor of the mean of two signed samples, one extra bit for the sum.
    function automatic smp_t mid_floor(smp_t a, smp_t b);
        logic signed [SMP_W:0] sum;
        sum = {a[SMP_W-1], a} + {b[SMP_W-1], b};
        return sum[SMP_W:1];
    endfunction

    // Pick the concealment action for a held sample.
    function automatic act_e choose(logic cur_bad, logic before_bad,
                                    logic after_bad, logic any_good);
        if (!cur_bad)
            return ACT_PASS;
        else if (!any_good)
            return ACT_SILENT;
        else if (!before_bad && !after_bad)
            return ACT_BLEND;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/conceal_chan.sv
module conceal_chan
    import conceal_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  tagged_smp_t nxt,
    output logic        emit,
    output smp_t        emit_val
);

    tagged_smp_t held;
    logic        held_vld;
    logic        before_bad;
    logic        any_good;
    smp_t        last_good;
    act_e        act;

    always_comb begin
        act = choose(held.bad, before_bad, nxt.bad, any_good);
        unique case (act)
            ACT_PASS:  emit_val = held.val;
            ACT_BLEND: emit_val = mid_floor(last_good, nxt.val);
            ACT_HOLD:  emit_val = last_good;
            default:   emit_val = '0;
        endcase
        emit = take && held_vld;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held       <= '0;
            held_vld   <= 1'b0;
            before_bad <= 1'b0;
            any_good   <= 1'b0;
            last_good  <= '0;
        end else if (take) begin
            held     <= nxt;
            held_vld <= 1'b1;
            if (held_vld) begin
                before_bad <= held.bad;
                if (!held.bad) begin
                    last_good <= held.val;
                    any_good  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/conceal_out.sv
module conceal_out
    import conceal_pkg::*;
#(
    parameter int CW = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] ld_chan,
    input  smp_t          ld_val,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [CW-1:0] out_chan,
    output smp_t          out_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_chan  <= ld_chan;
            out_data  <= ld_val;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/conceal_top.sv
module conceal_top
    import conceal_pkg::*;
#(
    parameter int NUM_CH = CH_N,
    localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [CW-1:0]    in_chan,
    input  logic             in_flag,
    input  logic [SMP_W-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [CW-1:0]    out_chan,
    output logic [SMP_W-1:0] out_data
);

    logic        acc;
    tagged_smp_t nxt;
    logic [NUM_CH-1:0] take_v;
    logic [NUM_CH-1:0] emit_v;
    smp_t        emit_d [NUM_CH];
    logic        load;
    smp_t        load_val;
    smp_t        out_s;

    assign in_ready = !out_valid || out_ready;
    assign acc      = in_valid && in_ready;
    assign nxt      = '{bad: in_flag, val: smp_t'(in_data)};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign take_v[c] = acc && (in_chan == CW'(c));
        conceal_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .take     (take_v[c]),
            .nxt      (nxt),
            .emit     (emit_v[c]),
            .emit_val (emit_d[c])
        );
    end

    always_comb begin
        load     = |emit_v;
        load_val = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (emit_v[c]) load_val = emit_d[c];
        end
    end

    conceal_out #(.CW(CW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .ld_chan   (in_chan),
        .ld_val    (load_val),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_chan  (out_chan),
        .out_data  (out_s)
    );

    assign out_data = out_s;

endmodule

// File: rtl/conceal_chk.sv
module conceal_chk #(
    parameter int NUM_CH = 2,
    parameter int CW = 1,
    parameter int SW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic [CW-1:0] in_chan,
    input logic          in_flag,
    input logic [SW-1:0] in_data,
    input logic          out_valid,
    input logic          out_ready,
    input logic [CW-1:0] out_chan,
    input logic [SW-1:0] out_data
);

    logic          acc;
    logic          seen  [NUM_CH];
    logic          pflag [NUM_CH];
    logic [SW-1:0] pdata [NUM_CH];

    assign acc = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CH; c++) begin
                seen[c]  <= 1'b0;
                pflag[c] <= 1'b0;
                pdata[c] <= '0;
            end
        end else if (acc) begin
            seen[in_chan]  <= 1'b1;
            pflag[in_chan] <= in_flag;
            pdata[in_chan] <= in_data;
        end
    end

    // R8
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));

    // R7
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(acc));

    // R6
    first_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !seen[in_chan]) |=> !out_valid);

    // R6
    chan_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && seen[in_chan]) |=> (out_valid && out_chan == $past(in_chan)));

    // R1
    clean_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && seen[in_chan] && !pflag[in_chan]) |=> (out_data == $past(pdata[in_chan])));

endmodule

bind conceal_top conceal_chk #(.NUM_CH(NUM_CH), .CW(CW), .SW(conceal_pkg::SMP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_chan   (in_chan),
    .in_flag   (in_flag),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_chan  (out_chan),
    .out_data  (out_data)
);

// File: tb/conceal_top_test.sv
module conceal_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [0:0]  in_chan = '0;
    logic        in_flag = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [0:0]  out_chan;
    logic [15:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    conceal_top uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan),
        .in_flag(in_flag), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_chan(out_chan), .out_data(out_data)
    );

    // {req code, chan, flag, data, expect valid, expect data}
    localparam int NV = 20;
    localparam logic [37:0] VEC [NV] = '{
        {3'd6, 1'b0, 1'b0,  16'sd100,    1'b0,  16'sd0},
        {3'd6, 1'b1, 1'b1,  16'sd50,     1'b0,  16'sd0},
        {3'd1, 1'b0, 1'b0,  16'sd200,    1'b1,  16'sd100},
        {3'd4, 1'b1, 1'b0, -16'sd30,     1'b1,  16'sd0},
        {3'd1, 1'b0, 1'b1,  16'sd999,    1'b1,  16'sd200},
        {3'd5, 1'b1, 1'b0, -16'sd11,     1'b1, -16'sd30},
        {3'd2, 1'b0, 1'b0,  16'sd301,    1'b1,  16'sd250},
        {3'd5, 1'b1, 1'b1,  16'sd7,      1'b1, -16'sd11},
        {3'd2, 1'b1, 1'b0, -16'sd20,     1'b1, -16'sd16},
        {3'd1, 1'b0, 1'b1,  16'sd5,      1'b1,  16'sd301},
        {3'd3, 1'b0, 1'b1,  16'sd6,      1'b1,  16'sd301},
        {3'd3, 1'b0, 1'b0,  16'sd400,    1'b1,  16'sd301},
        {3'd1, 1'b0, 1'b0,  16'sd401,    1'b1,  16'sd400},
        {3'd5, 1'b1, 1'b1,  16'sd0,      1'b1, -16'sd20},
        {3'd2, 1'b1, 1'b0,  16'h8000,    1'b1, -16'sd16394},
        {3'd1, 1'b1, 1'b0,  16'sd32767,  1'b1,  16'h8000},
        {3'd1, 1'b0, 1'b1,  16'sd1,      1'b1,  16'sd401},
        {3'd1, 1'b1, 1'b1,  16'sd3,      1'b1,  16'sd32767},
        {3'd2, 1'b1, 1'b0,  16'sd32767,  1'b1,  16'sd32767},
        {3'd2, 1'b0, 1'b0, -16'sd1,      1'b1,  16'sd200}
    };

    function automatic string req_name(logic [2:0] code);
        case (code)
            3'd1:    return "R1";
            3'd2:    return "R2";
            3'd3:    return "R3";
            3'd4:    return "R4";
            3'd5:    return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, $signed(got), $signed(exp));
        end
    endtask

    // Present one sample before a rising edge, drop it 1 time unit after.
    task automatic send(logic ch, logic fl, logic [15:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_chan  = ch;
        in_flag  = fl;
        in_data  = d;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R8 reset state
        check("R8", "out_valid after reset", 32'(out_valid), 32'd0);
        check("R8", "in_ready after reset", 32'(in_ready), 32'd1);

        for (int i = 0; i < NV; i++) begin
            logic [37:0] v;
            v = VEC[i];
            send(v[34], v[33], v[32:17]);
            check(req_name(v[37:35]), "out_valid", 32'(out_valid), 32'(v[16]));
            if (v[16]) begin
                check(req_name(v[37:35]), "out_data", 32'($signed(out_data)), 32'($signed(v[15:0])));
                check("R6", "out_chan", 32'(out_chan), 32'(v[34]));
            end
        end

        // R7 stall: output still holds 200 on channel 0
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_chan   = 1'b0;
        in_flag   = 1'b0;
        in_data   = 16'sd777;
        #1;
        check("R7", "in_ready while stalled", 32'(in_ready), 32'd0);
        @(posedge clk);
        #1;
        check("R7", "out_valid held", 32'(out_valid), 32'd1);
        check("R7", "out_data held", 32'(out_data), 32'd200);
        @(negedge clk);
        out_ready = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        check("R7", "released output of -1", 32'($signed(out_data)), -32'sd1);
        send(1'b0, 1'b0, 16'sd5);
        check("R7", "stalled sample taken once", 32'(out_data), 32'd777);

        // R8 / R4: history cleared by reset
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        check("R8", "out_valid after second reset", 32'(out_valid), 32'd0);
        send(1'b0, 1'b1, 16'sd10);
        check("R8", "no output for first sample after reset", 32'(out_valid), 32'd0);
        send(1'b0, 1'b0, 16'sd20);
        check("R4", "flagged with no clean history", 32'(out_data), 32'd0);
        check("R4", "flagged with no clean history valid", 32'(out_valid), 32'd1);

        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule